// File: doc/BRIEF.md
# Converter Serial Port Mode Logic

This block is the digital serial port of a sampling converter. A rising edge on the convert strobe starts a conversion. At the same edge the block samples the serial data input and the serial clock. From them it chooses one of two interface styles. In select-gated mode the output is released only while a select is active. In cascade mode the output is always driven, and the block behaves as a link in a shift-register chain that carries the results of upstream converters to the host. The sampled levels also decide whether the result is preceded by a busy start bit, which a host can use as an interrupt.

All port pins are sampled as synchronous inputs on a faster system clock, and edge detectors replace any derived clocks. An external converter core reports completion with a one-cycle pulse and presents the 16-bit result. The block shifts that result out most significant bit first, one bit per serial-clock falling edge. It also drives the output-enable that controls the output pad.

Top module: `sar_serial_port`

## Requirements
- R1: At an accepted convert rising edge, serial data input high selects select-gated mode and low selects cascade mode. In select-gated mode the output-enable stays 0 for the whole conversion, whatever the select does.
- R2: In cascade mode, serial clock high at the convert rising edge enables a start bit. After completion the output shows 1 until the first falling edge, then the result from the most significant bit. Serial clock low at that edge gives no start bit.
- R3: In select-gated mode the select is active when the convert strobe or the serial data input is low. If the select is active when the conversion completes, the output-enable goes to 1 and the output is 0 (the start bit). The result follows from the first falling edge.
- R4: In select-gated mode without a start bit, the output-enable goes to 1 once the select becomes active after completion. The output shows the most significant bit, and each later serial-clock falling edge moves to the next bit.
- R5: In select-gated mode the output-enable returns to 0 after the 16th falling edge, or after the 17th when a start bit was sent. Further falling edges do not re-enable it.
- R6: In select-gated mode a select that goes inactive after completion ends the read. The output-enable then stays 0 until the next conversion, even if the select becomes active again.
- R7: In cascade mode the output-enable is always 1. The serial data input is shifted in on every falling edge. The level sampled at falling edge k appears on the output after falling edge k+15 (k+16 with a start bit).
- R8: A started conversion runs to completion. Convert rising edges during it are ignored and do not change the mode. A completion pulse arriving while no conversion is running is ignored and does not reload the result.
- R9: In cascade mode the output is 0 during a conversion. Serial-clock falling edges during a conversion do not shift. The new result is loaded only at completion.
- R10: After reset the output-enable is 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than all port pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_i | input | 1 | Convert strobe; rising edge starts a conversion |
| sdi_i | input | 1 | Serial data input: mode strap, select, or upstream data |
| sck_i | input | 1 | Serial clock; falling edges advance the output |
| conv_done_i | input | 1 | One-cycle pulse from the converter core at completion |
| result_i | input | 16 | Conversion result, valid with conv_done_i |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output-enable for the serial data pad (0 means high impedance) |

## Verification
The hardest case to reach is the select-gated read that is closed early and then reopened. Reaching it takes a conversion completed with the convert strobe held high, a partial read framed only by the data-input select, then a release of that select, then a second activation. The bench drives this four-wire sequence directly and checks that the pad stays released afterwards. A second hard case is a convert edge that arrives mid-conversion with the data input low. That strobe would pick cascade mode if it were accepted, so the bench checks that the output-enable stays 0. It then reads the earlier result back after an out-of-turn completion pulse.

// File: rtl/sport_pkg.sv
// Package: shared types and default sizes for the converter serial port.
package sport_pkg;
    // Default width of a conversion result.
    localparam int unsigned RESULT_W_DEF = 16;

    // Interface style latched at the convert edge.
    typedef enum logic {
        MODE_GATED = 1'b0,
        MODE_CHAIN = 1'b1
    } port_mode_e;
endpackage

// File: rtl/sport_edge.sv
// Module: single-polarity edge detector for a pin sampled on the system clock.
// Assumes the pin is already synchronous to clk. RISING picks the polarity.
module sport_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic lvl_q;

    // Hold last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = lvl & ~lvl_q;
        end else begin : g_fall
            assign pulse = ~lvl & lvl_q;
        end
    endgenerate
endmodule

// File: rtl/sport_mode.sv
// Module: conversion and mode state of the serial port.
// Latches the interface style and the start-bit choice and tracks whether a
// conversion runs and whether a result is ready. It also records whether a
// gated read has been closed. Assumes conv_done is a one-cycle pulse.
module sport_mode
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnv_rise,
    input  logic       sdi,
    input  logic       sck,
    input  logic       sel_act,
    input  logic       sel_off,
    input  logic       conv_done,
    output port_mode_e mode,
    output logic       busy,
    output logic       converting,
    output logic       valid,
    output logic       closed,
    output logic       load
);
    logic start_ok;

    // Only a convert edge outside a conversion is honoured.
    assign start_ok = cnv_rise & ~converting;
    // Completion counts only while a conversion runs.
    assign load     = conv_done & converting;

    // Latch the mode at the start of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode <= MODE_GATED;
        else if (start_ok) mode <= sdi ? MODE_GATED : MODE_CHAIN;
    end

    // Start-bit choice: from sck in cascade mode, from the select at completion in gated mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                         busy <= 1'b0;
        else if (start_ok)                  busy <= ~sdi & sck;
        else if (load && mode == MODE_GATED) busy <= sel_act;
    end

    // Conversion in flight and result-ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            converting <= 1'b0;
            valid      <= 1'b0;
        end else if (start_ok) begin
            converting <= 1'b1;
            valid      <= 1'b0;
        end else if (load) begin
            converting <= 1'b0;
            valid      <= 1'b1;
        end
    end

    // A gated read ends for good once the select goes inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    closed <= 1'b0;
        else if (start_ok)                             closed <= 1'b0;
        else if (sel_off && valid && mode == MODE_GATED) closed <= 1'b1;
    end

    // R8: the mode cannot change while a conversion is in flight.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        converting |=> $stable(mode));
endmodule

// File: rtl/sport_shift.sv
// Module: result shift register with bit counter.
// Loads a result (plus an optional start bit) and moves one bit per enable.
// Fills from the serial input and reports when the framed length has been sent.
// Assumes load and shift_en never need to act in the same cycle; load wins.
module sport_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         busy,
    input  logic         chain,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic [W-1:0] result,
    output logic         bit_o,
    output logic         done
);
    localparam int unsigned CW = $clog2(W + 2);
    localparam logic [CW-1:0] LEN_PLAIN = CW'(W);
    localparam logic [CW-1:0] LEN_BUSY  = CW'(W + 1);

    logic [W:0]    sh;
    logic [CW-1:0] cnt;

    // Load a fresh result, or advance one bit with upstream fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= {busy & chain, result};
            cnt <= '0;
        end else if (shift_en) begin
            sh <= {sh[W-1:0], sdi};
            if (cnt != LEN_BUSY) cnt <= cnt + CW'(1);
        end
    end

    // With a start bit the frame is one bit longer and taps one place higher.
    assign bit_o = busy ? sh[W] : sh[W-1];
    assign done  = cnt >= (busy ? LEN_BUSY : LEN_PLAIN);
endmodule

// File: rtl/sar_serial_port.sv
// Module: top of the converter serial port mode logic.
// Samples the pins on clk, finds edges, and drives the pad data and enable
// for the gated and cascade styles. Assumes all pins are synchronous to clk.
module sar_serial_port
    import sport_pkg::*;
#(
    parameter int unsigned RESULT_W = RESULT_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnv_i,
    input  logic                sdi_i,
    input  logic                sck_i,
    input  logic                conv_done_i,
    input  logic [RESULT_W-1:0] result_i,
    output logic                sdo_o,
    output logic                sdo_oe_o
);
    logic       cnv_rise, sck_fall, sel_off;
    logic       sel_act;
    port_mode_e mode_q;
    logic       busy_q, converting_q, valid_q, closed_q, load;
    logic       is_chain, shift_en, data_bit, frame_done;

    // Select is active when either the strobe or the data input is low.
    assign sel_act = ~cnv_i | ~sdi_i;

    sport_edge #(.RISING(1'b1)) u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cnv_i), .pulse(cnv_rise));
    sport_edge #(.RISING(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sck_i), .pulse(sck_fall));
    sport_edge #(.RISING(1'b0)) u_sel_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sel_act), .pulse(sel_off));

    sport_mode u_mode (
        .clk(clk), .rst_n(rst_n), .cnv_rise(cnv_rise), .sdi(sdi_i),
        .sck(sck_i), .sel_act(sel_act), .sel_off(sel_off),
        .conv_done(conv_done_i), .mode(mode_q), .busy(busy_q),
        .converting(converting_q), .valid(valid_q), .closed(closed_q),
        .load(load));

    assign is_chain = (mode_q == MODE_CHAIN);

    // Shift on a falling edge once a result is ready; a gated read needs an open window.
    assign shift_en = sck_fall & valid_q &
                      (is_chain | (sel_act & ~closed_q & ~frame_done));

    sport_shift #(.W(RESULT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .busy(busy_q),
        .chain(is_chain), .shift_en(shift_en), .sdi(sdi_i),
        .result(result_i), .bit_o(data_bit), .done(frame_done));

    // Pad control: cascade always drives; gated drives only inside an open read.
    always_comb begin
        if (is_chain) begin
            sdo_oe_o = 1'b1;
            sdo_o    = valid_q & data_bit;
        end else begin
            sdo_oe_o = valid_q & sel_act & ~closed_q & ~frame_done;
            sdo_o    = sdo_oe_o & data_bit;
        end
    end

    // R1: gated mode keeps the pad released while converting.
    p_gated_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_chain && converting_q) |-> !sdo_oe_o);
    // R3: active select at completion yields a driven low start bit next cycle.
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !is_chain && sel_act) |=> (!sel_act || (sdo_oe_o && !sdo_o)));
    // R5: a completed gated frame leaves the pad released.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_chain && frame_done && valid_q) |-> !sdo_oe_o);
    // R6: a closed gated read never re-drives the pad.
    p_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_chain && closed_q) |-> !sdo_oe_o);
    // R7: cascade mode always drives the pad.
    p_chain_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_chain |-> sdo_oe_o);
    // R9: cascade output is low during a conversion.
    p_chain_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_chain && converting_q) |-> !sdo_o);
endmodule

// File: tb/sim_sar_serial_port.sv
// Bench: scoreboard of expected serial bits, filled by a driver task and
// drained by a reader task that compares them with the pad.
module sim_sar_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0, sdi = 1'b0, sck = 1'b0, conv_done = 1'b0;
    logic [15:0] result = '0;
    logic        sdo, sdo_oe;
    int          total = 0;
    int          bad = 0;
    logic        exp_q[$];

    always #5 clk = ~clk;

    sar_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sdi_i(sdi), .sck_i(sck),
        .conv_done_i(conv_done), .result_i(result),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver side: queue the top n bits of a word, MSB first.
    task automatic push_word(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) exp_q.push_back(w[i]);
    endtask

    // Reader side: compare the pad with the queue, one bit per sck falling edge.
    task automatic read_bits(input int n, input bit drive_up,
                             input logic [15:0] up, input string req);
        for (int k = 1; k <= n; k++) begin
            logic e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'bx;
            chk(req, sdo_oe, 1'b1);
            chk(req, sdo, e);
            if (drive_up) sdi = (k <= 16) ? up[16 - k] : 1'b0;
            sck = 1'b1; tick(2);
            sck = 1'b0; tick(2);
        end
    endtask

    task automatic start_conv(input logic s_di, input logic s_ck);
        sdi = s_di; sck = s_ck; tick(1);
        cnv = 1'b1; tick(2);
    endtask

    task automatic finish_conv(input logic [15:0] w);
        result = w; conv_done = 1'b1; tick(1);
        conv_done = 1'b0; tick(2);
    endtask

    task automatic sck_pulse();
        sck = 1'b1; tick(2);
        sck = 1'b0; tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        chk("R10 oe", sdo_oe, 1'b0);
        chk("R10 sdo", sdo, 1'b0);

        // Three-wire gated read, no start bit.
        start_conv(1'b1, 1'b0);
        chk("R1 gated quiet", sdo_oe, 1'b0);
        finish_conv(16'hA5C3);
        chk("R4 not yet selected", sdo_oe, 1'b0);
        cnv = 1'b0; tick(2);
        push_word(16'hA5C3, 16);
        read_bits(16, 1'b0, 16'h0, "R4 data");
        chk("R5 release after 16", sdo_oe, 1'b0);
        sck_pulse();
        chk("R5 stays released", sdo_oe, 1'b0);

        // Three-wire gated read with start bit.
        start_conv(1'b1, 1'b0);
        cnv = 1'b0; tick(2);
        chk("R1 quiet with select", sdo_oe, 1'b0);
        finish_conv(16'h3C96);
        chk("R3 start oe", sdo_oe, 1'b1);
        chk("R3 start low", sdo, 1'b0);
        exp_q.push_back(1'b0);
        push_word(16'h3C96, 16);
        read_bits(17, 1'b0, 16'h0, "R3 data");
        chk("R5 release after 17", sdo_oe, 1'b0);

        // Four-wire gated read closed early.
        start_conv(1'b1, 1'b0);
        finish_conv(16'h0F0F);
        chk("R4 four-wire idle", sdo_oe, 1'b0);
        sdi = 1'b0; tick(2);
        push_word(16'h0F0F, 5);
        read_bits(5, 1'b0, 16'h0, "R4 partial");
        sdi = 1'b1; tick(2);
        chk("R6 closed on release", sdo_oe, 1'b0);
        sdi = 1'b0; tick(2);
        chk("R6 stays closed", sdo_oe, 1'b0);
        sck_pulse();
        chk("R6 closed after edge", sdo_oe, 1'b0);

        // Ignored convert edge and stray completion.
        sdi = 1'b1; cnv = 1'b0; tick(2);
        start_conv(1'b1, 1'b0);
        sdi = 1'b0; cnv = 1'b0; tick(2);
        cnv = 1'b1; tick(2);
        chk("R8 mode kept", sdo_oe, 1'b0);
        sdi = 1'b1; tick(2);
        finish_conv(16'hD24B);
        finish_conv(16'h1111);
        cnv = 1'b0; tick(2);
        push_word(16'hD24B, 16);
        read_bits(16, 1'b0, 16'h0, "R8 first result");

        // Cascade mode, no start bit, with upstream data.
        sdi = 1'b0; tick(2);
        start_conv(1'b0, 1'b0);
        chk("R7 chain oe", sdo_oe, 1'b1);
        chk("R9 chain low", sdo, 1'b0);
        sck_pulse();
        sck_pulse();
        chk("R9 no shift while converting", sdo, 1'b0);
        finish_conv(16'h9A61);
        push_word(16'h9A61, 16);
        push_word(16'h5E2B, 16);
        read_bits(32, 1'b1, 16'h5E2B, "R7 pass-through");
        chk("R7 chain oe after", sdo_oe, 1'b1);

        // Cascade mode with start bit.
        sdi = 1'b0; cnv = 1'b0; tick(2);
        start_conv(1'b0, 1'b1);
        chk("R2 low while converting", sdo, 1'b0);
        sck = 1'b0; tick(2);
        finish_conv(16'h7E18);
        chk("R2 start high", sdo, 1'b1);
        exp_q.push_back(1'b1);
        push_word(16'h7E18, 16);
        read_bits(17, 1'b1, 16'h0, "R2 data");
        chk("R2 upstream after frame", sdo, 1'b0);
        chk("R9 scoreboard drained", exp_q.size() == 0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule